// File: doc/BRIEF.md
# Special Register Overlay Decoder

This block sits in front of a word-addressed main storage port and takes over the lowest 32 word addresses. A request to one of those addresses is served by an internal bank of 64-bit special registers and never reaches storage; every other address is forwarded unchanged to the external memory port. Each overlaid address has its own access rule. One reads as a constant zero. One exposes a channel field that only a hardware strobe can load. The mask word mixes hardwired ones, hardwired zeros and a writable band. The factor word changes only through a dedicated load strobe. The rest are plain storage: the two accumulator halves, the sixteen index words and the other addresses.

A caller drives one request per cycle: address, write enable and write data. Read data for both overlay and pass-through reads comes back registered, one cycle after the request, together with a valid flag. Two side ports let hardware load the channel field and the factor word without going through the program path.

Bit positions in this block are numbered big-endian. Word bit n is vector index 63-n, so bit 0 is the most significant bit.

Top module: `sro_overlay`

## Requirements
- R1: A request with address below 32 leaves mem_req low. A request with address 32 or above raises mem_req in the same cycle with mem_addr, mem_we and mem_wdata equal to the request's address, write enable and write data.
- R2: Address 0 always reads 64'h0, and writes to it have no effect.
- R3: Address 12 (mask) reads ones in bits 0–19 (vector [63:44]) and zeros in bits 48–63 (vector [15:0]). Only bits 20–47 (vector [43:16]) take written values.
- R4: Address 5 holds a 7-bit channel field in bits 12–18 (vector [51:45], chan_value[6] at bit 12). Only a cycle with chan_load high loads it. Program writes do not change it, and all other bits of address 5 read 0.
- R5: Addresses 16–31 are sixteen independent 64-bit index words that store every written bit.
- R6: Addresses 8 and 9 hold the left and right halves of the accumulator as two independent 64-bit words.
- R7: Address 14 (factor) changes only in a cycle with fac_load high, taking fac_value. Program writes to it have no effect.
- R8: A read request (req_valid high, req_we low) gives rd_valid high and the read word on rd_data in the next cycle. For pass-through reads, the read word is the mem_rdata seen during the request cycle. Write or idle cycles give rd_valid low in the next cycle.
- R9: After reset every special register reads 0, except the mask word, which reads 64'hFFFF_F000_0000_0000.
- R10: Addresses 1–4, 6, 7, 10, 11, 13 and 15 are plain 64-bit storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read request) |
| rd_data | output | 64 | Registered read data |
| chan_load | input | 1 | Hardware strobe that loads the channel field |
| chan_value | input | 7 | Channel field value |
| fac_load | input | 1 | Load-factor strobe |
| fac_value | input | 64 | Factor value |
| mem_req | output | 1 | Forwarded request to main storage |
| mem_we | output | 1 | Forwarded write enable |
| mem_addr | output | AW | Forwarded address |
| mem_wdata | output | 64 | Forwarded write data |
| mem_rdata | input | 64 | Storage read data, same cycle as mem_req |

## Verification
The assertions check on every cycle the address split between the overlay and storage, the one-cycle read timing, the pass-through data path, the zero word, and the hardwired bits of the mask and channel words. The bench's scenarios show the rules that depend on history. These are the writes dropped at the zero, channel and factor addresses, the writable band of the mask, the side-port loads, the independence of the accumulator halves and the index words, and the reset contents. A reference model tracks every write and checks the value of each later read against it.

// File: rtl/sro_pkg.sv
package sro_pkg;

    localparam int WORD_W   = 64;
    localparam int NUM_SREG = 32;
    localparam int IDX_W    = $clog2(NUM_SREG);
    localparam int CHAN_W   = 7;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  sidx_t;

    // Overlay addresses whose behaviour depends on their position
    localparam int A_ZERO   = 0;
    localparam int A_CHAN   = 5;
    localparam int A_MASK   = 12;
    localparam int A_FACTOR = 14;

    // Big-endian bit n lives at vector index 63-n
    localparam word_t MASK_ONES  = {20'hF_FFFF, 44'h0};
    localparam word_t MASK_WRITE = {20'h0, 28'hFFF_FFFF, 16'h0};
    localparam word_t CHAN_FIELD = {12'h0, 7'h7F, 45'h0};

    typedef struct packed {
        logic  hit;
        logic  we;
        sidx_t idx;
        word_t wdata;
    } sreg_req_t;

    // Bits a program store may change
    function automatic word_t prog_wmask(int i);
        case (i)
            A_ZERO, A_CHAN, A_FACTOR: return '0;
            A_MASK:                   return MASK_WRITE;
            default:                  return '1;
        endcase
    endfunction

    // Bits that read back from storage
    function automatic word_t read_keep(int i);
        case (i)
            A_ZERO:  return '0;
            A_CHAN:  return CHAN_FIELD;
            A_MASK:  return MASK_WRITE;
            default: return '1;
        endcase
    endfunction

    // Bits forced to one on read
    function automatic word_t read_force(int i);
        return (i == A_MASK) ? MASK_ONES : '0;
    endfunction

endpackage

// File: rtl/sro_decode.sv
module sro_decode
    import sro_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          req_valid,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  word_t         req_wdata,
    output sreg_req_t     sreq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output word_t         mem_wdata
);

    logic in_overlay;

    assign in_overlay = (req_addr[AW-1:IDX_W] == '0);

    always_comb begin
        sreq.hit   = req_valid && in_overlay;
        sreq.we    = req_we;
        sreq.idx   = req_addr[IDX_W-1:0];
        sreq.wdata = req_wdata;
    end

    assign mem_req   = req_valid && !in_overlay;
    assign mem_we    = req_we;
    assign mem_addr  = req_addr;
    assign mem_wdata = req_wdata;

endmodule

// File: rtl/sro_bank.sv
module sro_bank
    import sro_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  sreg_req_t         sreq,
    input  logic              chan_load,
    input  logic [CHAN_W-1:0] chan_value,
    input  logic              fac_load,
    input  word_t             fac_value,
    output word_t             rd_word
);

    word_t view [NUM_SREG];
    word_t chan_word;

    assign chan_word = {12'h0, chan_value, 45'h0};

    for (genvar i = 0; i < NUM_SREG; i++) begin : g_reg
        localparam word_t WM = prog_wmask(i);
        localparam word_t RK = read_keep(i);
        localparam word_t RF = read_force(i);
        word_t q;
        logic  sw_hit;

        assign sw_hit = sreq.hit && sreq.we && (sreq.idx == sidx_t'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else begin
                if (sw_hit)
                    q <= (q & ~WM) | (sreq.wdata & WM);
                if (i == A_CHAN && chan_load)
                    q <= chan_word;
                if (i == A_FACTOR && fac_load)
                    q <= fac_value;
            end
        end

        assign view[i] = (q & RK) | RF;
    end

    assign rd_word = view[sreq.idx];

endmodule

// File: rtl/sro_rdstage.sv
module sro_rdstage
    import sro_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_en,
    input  logic  sel_sreg,
    input  word_t sreg_word,
    input  word_t mem_word,
    output logic  rd_valid,
    output word_t rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_data <= sel_sreg ? sreg_word : mem_word;
        end
    end

endmodule

// File: rtl/sro_overlay.sv
module sro_overlay
    import sro_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [AW-1:0]     req_addr,
    input  logic [63:0]       req_wdata,
    output logic              rd_valid,
    output logic [63:0]       rd_data,
    input  logic              chan_load,
    input  logic [6:0]        chan_value,
    input  logic              fac_load,
    input  logic [63:0]       fac_value,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic [63:0]       mem_rdata
);

    sreg_req_t sreq;
    word_t     sreg_word;

    sro_decode #(.AW(AW)) u_dec (
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .sreq      (sreq),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    sro_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .sreq       (sreq),
        .chan_load  (chan_load),
        .chan_value (chan_value),
        .fac_load   (fac_load),
        .fac_value  (fac_value),
        .rd_word    (sreg_word)
    );

    sro_rdstage u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (req_valid && !req_we),
        .sel_sreg  (sreq.hit),
        .sreg_word (sreg_word),
        .mem_word  (mem_rdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/sro_overlay_chk.sv
module sro_overlay_chk #(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_we,
    input logic [AW-1:0] req_addr,
    input logic [63:0]   req_wdata,
    input logic          rd_valid,
    input logic [63:0]   rd_data,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [63:0]   mem_wdata,
    input logic [63:0]   mem_rdata
);

    logic low_addr;
    assign low_addr = (req_addr[AW-1:5] == '0);

    p_low_blocked_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && low_addr) |-> !mem_req);

    p_high_forwarded_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !low_addr) |->
            (mem_req && mem_addr == req_addr && mem_we == req_we && mem_wdata == req_wdata));

    p_zero_word_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_we && req_addr == '0) |=> (rd_data == 64'h0));

    p_mask_fixed_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_we && req_addr == AW'(12)) |=>
            (rd_data[63:44] == 20'hF_FFFF && rd_data[15:0] == 16'h0));

    p_chan_clean_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_we && req_addr == AW'(5)) |=>
            (rd_data[63:52] == 12'h0 && rd_data[44:0] == 45'h0));

    p_read_valid_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_we) |=> rd_valid);

    p_no_valid_r8: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_we) |=> !rd_valid);

    p_pass_data_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_we && !low_addr) |=> (rd_data == $past(mem_rdata)));

endmodule

bind sro_overlay sro_overlay_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
);

// File: tb/sim_sro_overlay.sv
`timescale 1ns/1ps
module sim_sro_overlay;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic          rd_valid;
    logic [63:0]   rd_data;
    logic          chan_load = 1'b0;
    logic [6:0]    chan_value = '0;
    logic          fac_load = 1'b0;
    logic [63:0]   fac_value = '0;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata;
    logic [63:0]   mem_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [63:0] model [32];

    always #2 clk = ~clk;

    function automatic logic [63:0] mem_fn(logic [AW-1:0] a);
        return ({46'h0, a} * 64'h9E37_79B9_7F4A_7C15) ^ 64'h5A5A_0F0F_C3C3_1234;
    endfunction

    assign mem_rdata = mem_fn(mem_addr);

    // Stored value after a program write, per the requirements
    function automatic logic [63:0] after_write(int i, logic [63:0] old, logic [63:0] d);
        case (i)
            0:       return 64'h0;
            5, 14:   return old;
            12:      return d & 64'h0000_0FFF_FFFF_0000;
            default: return d;
        endcase
    endfunction

    function automatic logic [63:0] view(int i);
        if (i == 12) return model[i] | 64'hFFFF_F000_0000_0000;
        return model[i];
    endfunction

    sro_overlay #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .chan_load(chan_load), .chan_value(chan_value),
        .fac_load(fac_load), .fac_value(fac_value), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a negative clock edge
    task automatic wr(logic [AW-1:0] a, logic [63:0] d);
        req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
        #1;
        if (a >= 32)
            chk(mem_req && mem_we && mem_addr == a && mem_wdata == d, "R1 write forward",
                {mem_req, mem_we, 46'h0, mem_addr}, {2'b11, 46'h0, a});
        else
            chk(!mem_req, "R1 low write blocked", {63'h0, mem_req}, 64'h0);
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
        chk(!rd_valid, "R8 no valid after write", {63'h0, rd_valid}, 64'h0);
        if (a < 32) model[a[4:0]] = after_write(int'(a[4:0]), model[a[4:0]], d);
    endtask

    task automatic rd(logic [AW-1:0] a, string tag);
        logic [63:0] exp;
        exp = (a < 32) ? view(int'(a[4:0])) : mem_fn(a);
        req_valid = 1'b1; req_we = 1'b0; req_addr = a;
        #1;
        if (a < 32)
            chk(!mem_req, "R1 low read blocked", {63'h0, mem_req}, 64'h0);
        else
            chk(mem_req && mem_addr == a, "R1 read forward", {46'h0, mem_addr}, {46'h0, a});
        @(negedge clk);
        req_valid = 1'b0;
        chk(rd_valid, {tag, " R8 valid"}, {63'h0, rd_valid}, 64'h1);
        chk(rd_data == exp, tag, rd_data, exp);
    endtask

    task automatic chan_pulse(logic [6:0] v);
        chan_load = 1'b1; chan_value = v;
        @(negedge clk);
        chan_load = 1'b0;
        model[5] = {12'h0, v, 45'h0};
    endtask

    task automatic fac_pulse(logic [63:0] v);
        fac_load = 1'b1; fac_value = v;
        @(negedge clk);
        fac_load = 1'b0;
        model[14] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 64'h0;
        void'($urandom(32'd1961));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!rd_valid && rd_data == 64'h0, "R9 reset outputs", rd_data, 64'h0);

        // R9: reset contents
        for (int i = 0; i < 32; i++) rd(AW'(i), "R9 reset value");

        // R2: zero word
        wr(0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(0, "R2 zero word");

        // R3: mask word
        wr(12, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12, "R3 mask all ones");
        wr(12, 64'h0);
        rd(12, "R3 mask cleared");
        wr(12, 64'h1234_5678_9ABC_DEF0);
        rd(12, "R3 mask pattern");

        // R4: channel field
        wr(5, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(5, "R4 channel store ignored");
        chan_pulse(7'h55);
        rd(5, "R4 channel load");
        wr(5, 64'h0);
        rd(5, "R4 channel kept");
        chan_pulse(7'h7F);
        rd(5, "R4 channel full field");

        // R7: factor word
        wr(14, 64'hDEAD_BEEF_0000_1111);
        rd(14, "R7 factor store ignored");
        fac_pulse(64'hCAFE_F00D_1357_2468);
        rd(14, "R7 factor load");
        wr(14, 64'h0);
        rd(14, "R7 factor kept");

        // R6: accumulator halves
        wr(8, 64'hAAAA_0000_FFFF_1111);
        wr(9, 64'h0123_4567_89AB_CDEF);
        rd(8, "R6 acc left");
        rd(9, "R6 acc right");

        // R5: index words
        for (int i = 16; i < 32; i++) wr(AW'(i), {32'(i) * 32'h0101_0101, ~(32'(i) << 3)});
        for (int i = 16; i < 32; i++) rd(AW'(i), "R5 index word");

        // R10: other plain words
        wr(3, 64'h8000_0000_0000_0001);
        wr(13, 64'h7FFF_FFFF_FFFF_FFFE);
        rd(3, "R10 plain word 3");
        rd(13, "R10 plain word 13");

        // R1/R8: pass-through, boundary addresses
        rd(32, "R8 pass-through 32");
        rd(31, "R5 boundary 31");
        rd(AW'(1 << (AW - 1)), "R8 pass-through high");
        wr(33, 64'h0F0F_0F0F_0F0F_0F0F);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int unsigned r;
            logic [AW-1:0] a;
            r = $urandom % 16;
            a = (r < 11) ? AW'($urandom % 32) : AW'(32 + $urandom % 200);
            if (r == 14) chan_pulse(7'($urandom));
            else if (r == 15) fac_pulse({$urandom, $urandom});
            else if ($urandom % 2 == 0) wr(a, {$urandom, $urandom});
            else rd(a, "R10 random read");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule